// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated line from an 8-bit period timer. The timer is extended below its least significant bit by a 2-bit fine count, so the position inside a period, and therefore the duty value, has 10-bit resolution. The fine count advances once per oscillator cycle when the prescaler is bypassed. With a prescale factor of 4 or 16 it is taken from the upper two bits of the prescaler count.

Software may rewrite the duty value, an 8-bit upper part and a 2-bit lower part, at any moment. The generator copies that value into a shadow register only when the timer reaches the period value and wraps. The waveform of the period that is running therefore never changes partway through. On each wrap the line is set unless the new duty is zero. It is cleared when the 10-bit position reaches the shadow duty.

The pin itself sits in a pad cell outside the block, so the block supplies a data bit and a drive enable for that pad. The block also reports the shadow duty and gives a one-cycle strobe at the end of every period.

Top module: `pwm10`

## Requirements
- R1: After reset, `duty_shadow` reads 0, `pwm_pad` and `period_end` are low, and the line stays low through the whole first period after enable, because the shadow duty is still 0.
- R2: With `presc_sel` encoded as 00 = ÷1, 01 = ÷4, 10 or 11 = ÷16, a period lasts (`period_val` + 1) × 4 × prescale clock cycles. `period_end` is high for exactly the last clock cycle of each period.
- R3: `duty_shadow` takes {`duty_msb`,`duty_lsb`} (`duty_msb` is the upper eight bits) in the cycle after `period_end`, and holds that value in every other cycle. Writes made in the middle of a period have no effect until the period ends.
- R4: When the shadow duty D is nonzero and smaller than the period count, the line goes high in the first cycle of a period. It stays high for exactly D × prescale clock cycles and is low for the rest of the period.
- R5: A shadow duty of 0 keeps the line low for the whole period. There is no set at the start of that period.
- R6: A shadow duty equal to or larger than (`period_val` + 1) × 4 keeps the line high for the whole period.
- R7: `pwm_pad_en` equals `pin_oe`. `pwm_pad` carries the line level while `pin_oe` is 1 and is 0 while `pin_oe` is 0. The timing of the line does not depend on `pin_oe`.
- R8: While `pwm_en` is 0, the timer and fine count are held at zero, the line is low and the shadow duty is kept. After re-enable, the line stays low until the first period end.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_en | input | 1 | Runs the time base when 1 |
| pin_oe | input | 1 | Output enable for the pad |
| presc_sel | input | 2 | Prescale select: 00 ÷1, 01 ÷4, 1x ÷16 |
| period_val | input | 8 | Terminal count of the period timer |
| duty_msb | input | 8 | Upper eight bits of the duty value |
| duty_lsb | input | 2 | Lower two bits of the duty value |
| pwm_pad | output | 1 | Data bit to the pad cell |
| pwm_pad_en | output | 1 | Drive enable to the pad cell |
| duty_shadow | output | 10 | Read-back of the shadow duty |
| period_end | output | 1 | One-cycle strobe in the last cycle of a period |

## Verification
The bound checker checks several rules on every cycle. The period-end strobe never lasts two cycles. The shadow register changes only right after that strobe, and then to the duty inputs of the strobe cycle. The line rises only just after a period end. A zero shadow duty and a disabled block both force the line low, and the pad stays quiet while it is not driven. Only the bench's scenarios can show the exact high time and period length for each prescale factor and period value. The same holds for the full-high case when the duty exceeds the period count, for a mid-period write taking effect one period later, and for the first period after reset or re-enable being low.

// File: rtl/pwm10_pkg.sv
`timescale 1ns/1ps
package pwm10_pkg;
  // Largest prescaler width in bits (divide-by-16).
  localparam int unsigned PRE_LOG2_MAX = 4;

  // Number of prescaler bits that sit below the fine count.
  function automatic int unsigned presc_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 2;
      default: return 4;
    endcase
  endfunction

  // Last value of the sub-timer counter before the 8-bit timer advances.
  function automatic int unsigned sub_last(input logic [1:0] sel, input int unsigned fine_w);
    return (1 << (fine_w + presc_shift(sel))) - 1;
  endfunction
endpackage

// File: rtl/pwm10_timebase.sv
`timescale 1ns/1ps
module pwm10_timebase
  import pwm10_pkg::*;
#(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FINE_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [1:0]                sel,
  input  logic [TMR_W-1:0]          period,
  output logic [TMR_W+FINE_W-1:0]   pos_next,
  output logic                      period_end
);
  localparam int unsigned SUB_W = FINE_W + PRE_LOG2_MAX;

  logic [SUB_W-1:0]  sub_q, sub_n, sub_lim;
  logic [TMR_W-1:0]  tmr_q, tmr_n;
  logic [FINE_W-1:0] fine_n;
  logic              step;

  always_comb begin
    sub_lim    = SUB_W'(sub_last(sel, FINE_W));
    step       = (sub_q >= sub_lim);
    period_end = en && step && (tmr_q == period);
    if (!en) begin
      sub_n = '0;
      tmr_n = '0;
    end else if (step) begin
      sub_n = '0;
      tmr_n = (tmr_q == period) ? '0 : tmr_q + 1'b1;
    end else begin
      sub_n = sub_q + 1'b1;
      tmr_n = tmr_q;
    end
    fine_n   = FINE_W'(sub_n >> presc_shift(sel));
    pos_next = {tmr_n, fine_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      tmr_q <= '0;
    end else begin
      sub_q <= sub_n;
      tmr_q <= tmr_n;
    end
  end
endmodule

// File: rtl/pwm10_duty_latch.sv
`timescale 1ns/1ps
module pwm10_duty_latch #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DUTY_W-1:0] duty_in,
  output logic [DUTY_W-1:0] shadow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow <= '0;
    else if (load) shadow <= duty_in;
  end
endmodule

// File: rtl/pwm10_level.sv
`timescale 1ns/1ps
module pwm10_level #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic [DUTY_W-1:0] shadow,
  input  logic [DUTY_W-1:0] pos_next,
  output logic              level
);
  // Set at the period wrap (unless the new duty is zero); clear when the
  // position about to be entered equals the shadow duty.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   level <= 1'b0;
    else if (!en)                 level <= 1'b0;
    else if (load)                level <= (duty_in != '0);
    else if (pos_next == shadow)  level <= 1'b0;
  end
endmodule

// File: rtl/pwm10.sv
`timescale 1ns/1ps
module pwm10 #(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FINE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwm_en,
  input  logic                    pin_oe,
  input  logic [1:0]              presc_sel,
  input  logic [TMR_W-1:0]        period_val,
  input  logic [TMR_W-1:0]        duty_msb,
  input  logic [FINE_W-1:0]       duty_lsb,
  output logic                    pwm_pad,
  output logic                    pwm_pad_en,
  output logic [TMR_W+FINE_W-1:0] duty_shadow,
  output logic                    period_end
);
  localparam int unsigned DUTY_W = TMR_W + FINE_W;

  logic [DUTY_W-1:0] duty_in;
  logic [DUTY_W-1:0] pos_next;
  logic [DUTY_W-1:0] shadow;
  logic              wrap_evt;
  logic              line_level;

  assign duty_in = {duty_msb, duty_lsb};

  pwm10_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (pwm_en),
    .sel        (presc_sel),
    .period     (period_val),
    .pos_next   (pos_next),
    .period_end (wrap_evt)
  );

  pwm10_duty_latch #(.DUTY_W(DUTY_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wrap_evt),
    .duty_in (duty_in),
    .shadow  (shadow)
  );

  pwm10_level #(.DUTY_W(DUTY_W)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (pwm_en),
    .load     (wrap_evt),
    .duty_in  (duty_in),
    .shadow   (shadow),
    .pos_next (pos_next),
    .level    (line_level)
  );

  assign pwm_pad     = pin_oe & line_level;
  assign pwm_pad_en  = pin_oe;
  assign duty_shadow = shadow;
  assign period_end  = wrap_evt;
endmodule

// File: rtl/pwm10_chk.sv
`timescale 1ns/1ps
module pwm10_chk #(
  parameter int unsigned DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [DUTY_W-1:0] duty_in,
  input logic [DUTY_W-1:0] shadow,
  input logic              wrap_evt,
  input logic              level,
  input logic              pad,
  input logic              pad_en
);
  assert_end_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> !wrap_evt);

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(shadow));

  assert_shadow_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (shadow == $past(duty_in)));

  assert_rise_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level) |-> $past(wrap_evt));

  assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow == '0) |-> !level);

  assert_pad_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_en |-> !pad);

  assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !level);
endmodule

bind pwm10 pwm10_chk #(.DUTY_W(TMR_W + FINE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (pwm_en),
  .duty_in  (duty_in),
  .shadow   (shadow),
  .wrap_evt (wrap_evt),
  .level    (line_level),
  .pad      (pwm_pad),
  .pad_en   (pwm_pad_en)
);

// File: tb/pwm10_bench.sv
`timescale 1ns/1ps
module pwm10_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwm_en;
  logic       pin_oe;
  logic [1:0] presc_sel;
  logic [7:0] period_val;
  logic [7:0] duty_msb;
  logic [1:0] duty_lsb;
  logic       pwm_pad, pwm_pad_en, period_end;
  logic [9:0] duty_shadow;

  always #2.5 clk = ~clk;

  pwm10 u_pwm10 (
    .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .pin_oe(pin_oe),
    .presc_sel(presc_sel), .period_val(period_val),
    .duty_msb(duty_msb), .duty_lsb(duty_lsb),
    .pwm_pad(pwm_pad), .pwm_pad_en(pwm_pad_en),
    .duty_shadow(duty_shadow), .period_end(period_end)
  );

  int  vecs = 0;
  int  bad  = 0;
  bit  chk_on = 0;
  bit  done = 0;
  int  k = 0;      // clocks elapsed in the current period
  int  sh = 0;     // model shadow duty
  bit  armed = 0;  // a period end has occurred since reset / enable

  function automatic int pfac(input logic [1:0] s);
    if (s == 2'b00) return 1;
    if (s == 2'b01) return 4;
    return 16;
  endfunction

  function automatic int period_clks();
    return (int'(period_val) + 1) * 4 * pfac(presc_sel);
  endfunction

  // Behavioural reference: counts clocks within a period.
  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; sh = 0; armed = 0;
    end else if (!pwm_en) begin
      k = 0; armed = 0;
    end else if (k == period_clks() - 1) begin
      k = 0; sh = int'({duty_msb, duty_lsb}); armed = 1;
    end else begin
      k++;
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      bit exp_lvl, exp_end;
      string tag;
      exp_lvl = armed && (k < sh * pfac(presc_sel));
      exp_end = pwm_en && (k == period_clks() - 1);
      vecs++;
      if (!armed)                        tag = "R8";
      else if (sh == 0)                  tag = "R5";
      else if (sh * pfac(presc_sel) >= period_clks()) tag = "R6";
      else                               tag = "R4";
      if (pwm_pad_en !== pin_oe) begin
        bad++; $display("FAIL R7 pad_en: got %0b exp %0b", pwm_pad_en, pin_oe);
      end
      if (pwm_pad !== (pin_oe & exp_lvl)) begin
        bad++; $display("FAIL %s pad k=%0d: got %0b exp %0b", tag, k, pwm_pad, pin_oe & exp_lvl);
      end
      if (int'(duty_shadow) != sh) begin
        bad++; $display("FAIL R3 shadow: got %0d exp %0d", duty_shadow, sh);
      end
      if (period_end !== exp_end) begin
        bad++; $display("FAIL R2 period_end k=%0d: got %0b exp %0b", k, period_end, exp_end);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_duty(input int d);
    duty_msb = 8'(d >> 2);
    duty_lsb = 2'(d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    rst_n = 0; pwm_en = 0; pin_oe = 1; presc_sel = 2'b00;
    period_val = 8'd3; set_duty(5);
    repeat (3) begin
      @(negedge clk);
      vecs++;
      // R1: reset state
      if (duty_shadow !== 10'd0 || pwm_pad !== 1'b0 || period_end !== 1'b0) begin
        bad++;
        $display("FAIL R1 reset: got shadow=%0d pad=%0b end=%0b exp 0/0/0",
                 duty_shadow, pwm_pad, period_end);
      end
    end
    @(posedge clk); #1;
    rst_n = 1; chk_on = 1;
    // R1/R2/R4: divide-by-1, period 16 clocks, duty 5
    pwm_en = 1;
    run(60);
    // R3: mid-period write takes effect only at the next period end
    set_duty(9);
    run(40);
    // R5: zero duty
    set_duty(0);
    run(40);
    // R6: duty above and equal to period count
    set_duty(1023);
    run(40);
    set_duty(16);
    run(40);
    set_duty(15);
    run(36);
    // R7: pad disabled then re-enabled
    pin_oe = 0;
    run(24);
    pin_oe = 1;
    run(10);
    // R8: disable mid-period, change configuration, re-enable
    pwm_en = 0;
    run(10);
    presc_sel = 2'b01; period_val = 8'd2; set_duty(7);
    pwm_en = 1;
    run(160);
    set_duty(1);
    run(100);
    pwm_en = 0;
    run(5);
    presc_sel = 2'b10; period_val = 8'd1; set_duty(3);
    pwm_en = 1;
    run(300);
    pwm_en = 0;
    run(5);
    presc_sel = 2'b11; set_duty(13);
    pwm_en = 1;
    run(270);
    // R8: disable while the line is high
    run(20);
    pwm_en = 0;
    run(8);
    pwm_en = 1;
    run(140);
    finish_run();
  end
endmodule